// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory request for a whole warp and turns it into the fewest naturally aligned memory transactions. The request holds one byte address for each of the 32 lanes, a mask of active lanes, and assumes 4-byte, word-aligned lane accesses. The block groups the active lanes by the 128-byte segment their address falls in. For each group it picks the smallest aligned transaction of 32, 64 or 128 bytes that covers every byte the group needs.

Transactions leave the block one at a time through a valid/ready handshake. Each carries a base address, a size code and a mask of the lanes it serves, so the load path can later hand the returned data back to those lanes. A new warp request is taken only when the previous one is fully drained. A one-cycle done pulse marks the end of each request.

Top module: `warp_coalescer`

## Requirements
- R1: 32 active lanes reading consecutive words from a 128-byte-aligned base produce exactly one transaction of size code 2 (128 bytes) at that base, with all 32 lane bits set.
- R2: A run of consecutive words that crosses a 128-byte boundary produces two transactions, one on each side of the boundary (base offset 64 gives two 64-byte transactions).
- R3: With a lane stride of 1024 bytes, every active lane gets its own transaction of size code 0 (32 bytes).
- R4: The size code of each transaction is the smallest of 0 (32 bytes), 1 (64 bytes) and 2 (128 bytes) whose aligned window covers all bytes the grouped lanes need inside their 128-byte segment.
- R5: Each transaction base is a multiple of its own size, and every lane marked in it has its whole word inside [base, base + size).
- R6: Lanes whose req_mask bit is clear never appear in txn_lanes and never add a transaction; an all-zero mask produces no transaction and only a done pulse.
- R7: Transactions of one request leave in strictly ascending base order, one per cycle while txn_ready is high. txn_lanes (bit i = lane i) marks exactly the active lanes whose address lies in that segment.
- R8: While txn_valid is high and txn_ready is low, txn_base, txn_size and txn_lanes hold steady.
- R9: After reset req_ready is 1 and txn_valid and done are 0. req_ready stays 0 while a request is being drained. done is high for exactly the one cycle after the last transaction is accepted, or after an empty request is accepted.
- R10: Lane strides of 2 and 4 words from an aligned base share segments: 32 lanes give 2 and 4 transactions of 128 bytes respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle, request taken when both valid and ready are high |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i in bits [ADDR_W*i +: ADDR_W] |
| req_mask | input | LANES | Active-lane mask, bit i = lane i |
| txn_valid | output | 1 | Transaction on offer |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | ADDR_W | Aligned transaction base address |
| txn_size | output | 2 | Size code: 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse when a request has been fully issued |

## Verification
The bench tries aligned unit stride (one full segment), unit stride starting mid-segment (a boundary split), 8- and 16-byte strides (segment sharing), a 1024-byte stride (full scatter), and compact lane clusters inside one 32- or 64-byte window (size reduction). Each of these patterns yields a different transaction count and size code. Masks with inactive lanes pointing at far-away addresses separate true lane filtering from accidental grouping, and an empty mask isolates the done path. Random bases, strides, windows and masks under a random ready signal then compare every issued transaction, in order, against a bench model, and they exercise the hold behaviour under back-pressure.

// File: rtl/coal_pkg.sv
// Package: shared helpers for the warp coalescer.
// Assumes nothing beyond elaboration-time constant arguments.
package coal_pkg;

    // Width of a code field able to hold n distinct values, never below 1.
    function automatic int unsigned code_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/coal_group.sv
// Module: coal_group
// Finds the lowest 128-byte segment touched by any still-pending lane, marks
// every pending lane in that segment, and reports the lowest start piece and
// the highest end piece (in minimum-transaction units) those lanes need.
// Assumes lane accesses are WORD_BYTES wide and do not cross a minimum piece.
module coal_group #(
    parameter int unsigned LANES      = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned SEG_LSB    = 7,
    parameter int unsigned MIN_LSB    = 5,
    localparam int unsigned SEG_W     = ADDR_W - SEG_LSB,
    localparam int unsigned PIECE_W   = SEG_LSB - MIN_LSB
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES-1:0]        pending,
    output logic [LANES-1:0]        group,
    output logic [SEG_W-1:0]        seg_min,
    output logic [PIECE_W-1:0]      lo_piece,
    output logic [PIECE_W-1:0]      hi_piece
);

    logic [SEG_W-1:0]   seg_l [LANES];
    logic [PIECE_W-1:0] st_l  [LANES];
    logic [PIECE_W-1:0] en_l  [LANES];
    logic               found;

    // Per-lane slicing of segment, start piece and end piece.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEG_LSB-1:0] last_byte;
        assign seg_l[i]   = addr[i*ADDR_W+SEG_LSB +: SEG_W];
        assign st_l[i]    = addr[i*ADDR_W+MIN_LSB +: PIECE_W];
        assign last_byte  = addr[i*ADDR_W +: SEG_LSB] + SEG_LSB'(WORD_BYTES - 1);
        assign en_l[i]    = last_byte[SEG_LSB-1:MIN_LSB];
        assign group[i]   = pending[i] && (seg_l[i] == seg_min);
    end

    // Minimum segment over all pending lanes.
    always_comb begin
        found   = 1'b0;
        seg_min = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && (!found || seg_l[i] < seg_min)) begin
                seg_min = seg_l[i];
                found   = 1'b1;
            end
        end
    end

    // Byte span of the selected group expressed as first and last piece.
    always_comb begin
        lo_piece = '1;
        hi_piece = '0;
        for (int i = 0; i < LANES; i++) begin
            if (group[i]) begin
                if (st_l[i] < lo_piece) lo_piece = st_l[i];
                if (en_l[i] > hi_piece) hi_piece = en_l[i];
            end
        end
    end

endmodule

// File: rtl/coal_size_pick.sv
// Module: coal_size_pick
// Chooses the smallest power-of-two window (in minimum pieces) that holds both
// the first and the last piece of a group, and returns its code and the
// aligned starting piece. Code k means 2^k minimum pieces.
// Assumes lo_piece <= hi_piece whenever the result is used.
module coal_size_pick #(
    parameter int unsigned PIECE_W = 2,
    localparam int unsigned NSIZE  = PIECE_W + 1,
    localparam int unsigned SZ_W   = coal_pkg::code_width(NSIZE)
) (
    input  logic [PIECE_W-1:0] lo_piece,
    input  logic [PIECE_W-1:0] hi_piece,
    output logic [SZ_W-1:0]    code,
    output logic [PIECE_W-1:0] base_piece
);

    // Walk from the largest size down so the smallest fitting one wins.
    always_comb begin
        code       = SZ_W'(NSIZE - 1);
        base_piece = '0;
        for (int k = NSIZE - 1; k >= 0; k--) begin
            if ((lo_piece >> k) == (hi_piece >> k)) begin
                code       = SZ_W'(k);
                base_piece = (lo_piece >> k) << k;
            end
        end
    end

    // The chosen code never names a size beyond one whole segment (R4).
    always_comb begin
        a_r4_code_in_range: assert (code <= SZ_W'(NSIZE - 1));
    end

endmodule

// File: rtl/warp_coalescer.sv
// Module: warp_coalescer (top)
// Holds one warp request, then issues one aligned transaction per touched
// segment, lowest segment first, each sized to the smallest aligned window
// covering its lanes. Pulses done after the last one is accepted.
// Assumes word-aligned lane addresses that do not wrap the address space.
module warp_coalescer import coal_pkg::*; #(
    parameter int unsigned LANES         = 32,
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned WORD_BYTES    = 4,
    parameter int unsigned MIN_TXN_BYTES = 32,
    parameter int unsigned SEG_BYTES     = 128,
    localparam int unsigned SEG_LSB      = $clog2(SEG_BYTES),
    localparam int unsigned MIN_LSB      = $clog2(MIN_TXN_BYTES),
    localparam int unsigned PIECE_W      = SEG_LSB - MIN_LSB,
    localparam int unsigned SEG_W        = ADDR_W - SEG_LSB,
    localparam int unsigned NSIZE        = PIECE_W + 1,
    localparam int unsigned SZ_W         = code_width(NSIZE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [SZ_W-1:0]         txn_size,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    done
);

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pending;
    logic                    busy;
    logic [LANES-1:0]        group;
    logic [SEG_W-1:0]        seg_min;
    logic [PIECE_W-1:0]      lo_piece, hi_piece, base_piece;
    logic [SZ_W-1:0]         code;
    logic                    accept, fire;
    logic [LANES-1:0]        remain;

    coal_group #(
        .LANES(LANES), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
        .SEG_LSB(SEG_LSB), .MIN_LSB(MIN_LSB)
    ) u_group (
        .addr(addr_q), .pending(pending), .group(group),
        .seg_min(seg_min), .lo_piece(lo_piece), .hi_piece(hi_piece)
    );

    coal_size_pick #(.PIECE_W(PIECE_W)) u_pick (
        .lo_piece(lo_piece), .hi_piece(hi_piece),
        .code(code), .base_piece(base_piece)
    );

    assign accept    = req_valid && req_ready;
    assign fire      = txn_valid && txn_ready;
    assign remain    = pending & ~group;
    assign req_ready = !busy;
    assign txn_valid = busy;
    assign txn_lanes = group;
    assign txn_size  = code;
    assign txn_base  = {seg_min, base_piece, MIN_LSB'(0)};

    // Capture lane addresses when a request is taken.
    always_ff @(posedge clk) begin
        if (accept) addr_q <= req_addr;
    end

    // Request state: pending lanes, busy flag and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                pending <= req_mask;
                busy    <= |req_mask;
                done    <= ~|req_mask;
            end else if (fire) begin
                pending <= remain;
                if (remain == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    logic [ADDR_W-1:0] last_base;
    logic              have_last;

    // Remembers the previous issued base inside the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_base <= '0;
        end else if (accept) begin
            have_last <= 1'b0;
        end else if (fire) begin
            have_last <= 1'b1;
            last_base <= txn_base;
        end
    end

    a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_base & ((ADDR_W'(MIN_TXN_BYTES) << txn_size) - 1)) == '0));

    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && have_last) |-> (txn_base > last_base));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base)
                                       && $stable(txn_size) && $stable(txn_lanes)));

    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && remain == '0) |=> (done && !txn_valid));

    a_r6_lanes_active: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0 && (txn_lanes & ~pending) == '0));

    // Every served lane lies wholly inside the issued window (R5).
    always @(posedge clk) begin
        if (rst_n && txn_valid) begin
            for (int i = 0; i < LANES; i++) begin
                if (txn_lanes[i]) begin
                    a_r5_lane_inside: assert (
                        addr_q[i*ADDR_W +: ADDR_W] >= txn_base &&
                        addr_q[i*ADDR_W +: ADDR_W] + ADDR_W'(WORD_BYTES)
                            <= txn_base + (ADDR_W'(MIN_TXN_BYTES) << txn_size));
                end
            end
        end
    end

endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1023:0] req_addr = '0;
    logic [31:0]   req_mask = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [31:0]   txn_base;
    logic [1:0]    txn_size;
    logic [31:0]   txn_lanes;
    logic          done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] a [32];
    logic [31:0] mask;
    logic [31:0] exp_base  [32];
    logic [1:0]  exp_code  [32];
    logic [31:0] exp_lanes [32];
    int          exp_n;

    warp_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_base(txn_base), .txn_size(txn_size),
        .txn_lanes(txn_lanes), .done(done)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 actual=%0d expected=<150000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Bench model: per segment, ascending, smallest aligned window holding
    // the first and last byte of the grouped lanes.
    task automatic compute_expected();
        logic [31:0] rem, g;
        logic [24:0] ms;
        logic [6:0]  lo, hi;
        bit          found;
        rem   = mask;
        exp_n = 0;
        while (rem != 0) begin
            found = 0;
            ms    = '0;
            for (int i = 0; i < 32; i++)
                if (rem[i] && (!found || a[i][31:7] < ms)) begin
                    ms = a[i][31:7];
                    found = 1;
                end
            g = '0; lo = 7'd127; hi = 7'd0;
            for (int i = 0; i < 32; i++)
                if (rem[i] && a[i][31:7] == ms) begin
                    g[i] = 1'b1;
                    if (a[i][6:0] < lo) lo = a[i][6:0];
                    if (a[i][6:0] + 7'd3 > hi) hi = a[i][6:0] + 7'd3;
                end
            if (lo[6:5] == hi[6:5]) begin
                exp_code[exp_n] = 2'd0;
                exp_base[exp_n] = {ms, lo[6:5], 5'b0};
            end else if (lo[6] == hi[6]) begin
                exp_code[exp_n] = 2'd1;
                exp_base[exp_n] = {ms, lo[6], 6'b0};
            end else begin
                exp_code[exp_n] = 2'd2;
                exp_base[exp_n] = {ms, 7'b0};
            end
            exp_lanes[exp_n] = g;
            exp_n++;
            rem = rem & ~g;
        end
    endtask

    // Issue one request and collect/compare its transactions.
    task automatic run_req(input bit always_rdy, input int want_n, input string tag);
        int got, cyc;
        bit held;
        logic [31:0] h_base, h_lanes;
        logic [1:0]  h_size;
        compute_expected();
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_mask  = mask;
        for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; cyc = 0; held = 0;
        h_base = '0; h_lanes = '0; h_size = '0;
        while (got < exp_n && cyc < 400) begin
            if (held) begin
                chk(txn_valid && txn_base == h_base && txn_size == h_size
                    && txn_lanes == h_lanes, "R8 hold under stall", txn_base, h_base);
            end
            txn_ready = always_rdy ? 1'b1 : ($urandom % 3 != 0);
            if (txn_valid) begin
                chk(req_ready == 1'b0, "R9 no accept while busy", 32'(req_ready), 0);
                if (txn_ready) begin
                    chk(txn_base == exp_base[got], "R5 base and R7 order", txn_base, exp_base[got]);
                    chk(txn_size == exp_code[got], "R4 size code", 32'(txn_size), 32'(exp_code[got]));
                    chk(txn_lanes == exp_lanes[got], "R7 lane mask R6", txn_lanes, exp_lanes[got]);
                    got++;
                    held = 0;
                end else begin
                    held = 1;
                    h_base = txn_base; h_size = txn_size; h_lanes = txn_lanes;
                end
            end
            cyc++;
            @(negedge clk);
        end
        txn_ready = 1'b0;
        chk(got == exp_n, "R7 all transactions issued", got, exp_n);
        if (always_rdy) chk(cyc == exp_n, "R7 one per cycle", cyc, exp_n);
        if (want_n >= 0) chk(got == want_n, tag, got, want_n);
        chk(done == 1'b1, "R9 done after last", 32'(done), 1);
        chk(txn_valid == 1'b0, "R9 idle after last", 32'(txn_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
    endtask

    task automatic fill_stride(input logic [31:0] base, input logic [31:0] step);
        for (int i = 0; i < 32; i++) a[i] = base + step * i;
    endtask

    initial begin
        void'($urandom(32'h5eed_c0a1));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 1);
        chk(txn_valid == 1'b0, "R9 reset valid", 32'(txn_valid), 0);
        chk(done == 1'b0, "R9 reset done", 32'(done), 0);
        rst_n = 1'b1;

        // R1 aligned unit stride
        fill_stride(32'h0000_1000, 4); mask = '1;
        run_req(1, 1, "R1 one 128B transaction");
        chk(exp_code[0] == 2'd2, "R1 model size", 32'(exp_code[0]), 2);

        // R2 boundary crossing
        fill_stride(32'h0000_2040, 4); mask = '1;
        run_req(1, 2, "R2 boundary split");

        // R3 large stride
        fill_stride(32'h0004_0000, 1024); mask = '1;
        run_req(1, 32, "R3 one per lane");

        // R4 32-byte window, inactive lanes far away (R6)
        fill_stride(32'h0003_0020, 4);
        for (int i = 8; i < 32; i++) a[i] = 32'h0900_0000 + 32'h1000 * i;
        mask = 32'h0000_00FF;
        run_req(1, 1, "R4 32B window R6 inactive ignored");

        // R4 64-byte window
        fill_stride(32'h0003_0080, 4); mask = 32'h0000_FFFF;
        run_req(1, 1, "R4 64B window");

        // R10 strides of 2 and 4 words
        fill_stride(32'h0000_5000, 8); mask = '1;
        run_req(1, 2, "R10 stride 2 words");
        fill_stride(32'h0000_6000, 16); mask = '1;
        run_req(0, 4, "R10 stride 4 words");

        // R6 empty mask
        fill_stride(32'h0000_7000, 1024); mask = '0;
        run_req(1, 0, "R6 empty mask");

        // Random mix under random back-pressure
        for (int r = 0; r < 80; r++) begin
            logic [31:0] base;
            int mode;
            base = $urandom & 32'h0FFF_FFFC;
            mode = $urandom % 5;
            case (mode)
                0: fill_stride(base, 4);
                1: fill_stride(base, 8);
                2: fill_stride(base, 16);
                3: fill_stride(base, 1024);
                default: for (int i = 0; i < 32; i++) a[i] = base + 4 * ($urandom % 128);
            endcase
            mask = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            run_req(0, -1, "R7 random");
        end

        summary();
        $finish;
    end

endmodule